// File: doc/BRIEF.md
# Bit-serial Montgomery multiplier over GF(2^m)

This block forms the Montgomery product c(x) = a(x)·b(x)·x^(-M) mod f(x) of two elements of a binary extension field held in polynomial basis. The field size M is set by a parameter; the reduction polynomial is supplied at run time with each operation. Each clock retires one multiplier bit, lowest first, by adding a_i·b(x) and a reduction multiple of f(x) to an accumulator and dividing by x.

The reduction decision for the following step comes from a small lookahead cell working in the same clock as the accumulator row. The row therefore never waits on the low bit it has just produced, so the per-cycle path is one AND level feeding a three-input XOR. A caller pulses `start` while the block is idle, waits for the one-cycle `done` pulse and reads `c_out`. The control pins are plain level/pulse signals with no back-pressure: an operation, once accepted, runs to completion, and `start` is only taken while `busy` is low.

Top module: `gf2m_mont_mul`

## Requirements
- R1: When `done` is high, `c_out` equals a·b·x^(-M) mod f for the operands captured at the accepted start; vectors are M bits wide, bit i holding the coefficient of x^i, additions are XOR and products AND.
- R2: The reduction polynomial is f(x) = x^M + f_in[M-1:1] + 1: the x^0 and x^M coefficients are always 1, and the value of `f_in[0]` has no effect on any result.
- R3: A start sampled at a rising edge makes `busy` high after that edge and keeps it high for M edges; `done` goes high after the (M+1)-th rising edge counted from and including the one that sampled start, in the same cycle `busy` drops.
- R4: `done` is high for exactly one cycle per operation.
- R5: `start` is ignored while `busy` is high; the operation in flight and its result are unchanged.
- R6: `a_in`, `b_in` and `f_in` are captured on the accepted start; changes to them while `busy` is high do not affect the result.
- R7: From `done` until the next accepted start, `c_out` holds its value.
- R8: After reset `busy` and `done` are low and `c_out` is zero.
- R9: Every step's accumulated sum has a zero constant coefficient, so the division by x is exact; the x^(M-1) coefficient of the new accumulator is the reduction bit of that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new product; taken only while idle |
| a_in | input | M | Multiplier operand, consumed lowest bit first |
| b_in | input | M | Multiplicand operand |
| f_in | input | M | Reduction polynomial coefficients x^1..x^(M-1) in bits M-1:1; bit 0 ignored |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-cycle pulse when `c_out` holds a new result |
| c_out | output | M | Accumulator; the Montgomery product once `done` pulses |

## Verification
The bench builds the block with M = 8 and runs it with two irreducible octic polynomials, 0x11B and 0x11D, the second showing that the modulus is truly a run-time input. A width of eight keeps the step-by-step model short while still reaching the extreme operands (zero, one, x^7 squared) and operands whose top bits force a reduction on every step. Results are checked both against a per-cycle model of the recurrence and against the independent identity c·x^M mod f = a·b mod f, and the runs include a cleared `f_in[0]`, a second start during a run and operand changes mid-run.

// File: rtl/gf2m_mont_pkg.sv
package gf2m_mont_pkg;
  // Width of the step counter for a field of size m.
  function automatic int step_cnt_w(input int m);
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction
endpackage

// File: rtl/gf2m_mont_row.sv
// One accumulate-and-divide row: s = acc + a_bit*b + d*f (with x^M term), next = s / x.
module gf2m_mont_row #(
  parameter int M = 8
) (
  input  logic [M-1:0] acc,
  input  logic [M-1:0] b_op,
  input  logic [M-1:0] f_op,
  input  logic         a_bit,
  input  logic         d_bit,
  output logic [M-1:0] acc_next,
  output logic         sum_lsb
);
  logic [M:0] sum;

  generate
    for (genvar j = 0; j < M; j++) begin : g_cell
      assign sum[j] = acc[j] ^ (a_bit & b_op[j]) ^ (d_bit & f_op[j]);
    end
  endgenerate
  // Leading coefficient of f is always 1.
  assign sum[M]   = d_bit;
  assign acc_next = sum[M:1];
  assign sum_lsb  = sum[0];
endmodule

// File: rtl/gf2m_mont_lookahead.sv
// Predicts the reduction bit of the next step from operand bits only,
// without waiting on the row output.
module gf2m_mont_lookahead (
  input  logic acc_b1,
  input  logic b_b0,
  input  logic b_b1,
  input  logic f_b1,
  input  logic a_bit,
  input  logic a_next,
  input  logic d_bit,
  output logic d_next
);
  assign d_next = (a_next & b_b0) ^ acc_b1 ^ (a_bit & b_b1) ^ (d_bit & f_b1);
endmodule

// File: rtl/gf2m_mont_ctrl.sv
module gf2m_mont_ctrl
  import gf2m_mont_pkg::*;
#(
  parameter int M = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic busy,
  output logic done
);
  localparam int CW = step_cnt_w(M);
  localparam logic [CW-1:0] LAST = CW'(M - 1);

  logic [CW-1:0] cnt;

  assign load = start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_on_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_no_done_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: rtl/gf2m_mont_mul.sv
module gf2m_mont_mul #(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  input  logic [M-1:0] f_in,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] c_out
);
  logic         load;
  logic [M-1:0] a_sr, b_q, f_q, acc, acc_next;
  logic         d_q, d_next, sum_lsb;

  gf2m_mont_ctrl #(.M(M)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .busy(busy), .done(done)
  );

  gf2m_mont_row #(.M(M)) u_row (
    .acc(acc), .b_op(b_q), .f_op(f_q), .a_bit(a_sr[0]), .d_bit(d_q),
    .acc_next(acc_next), .sum_lsb(sum_lsb)
  );

  gf2m_mont_lookahead u_look (
    .acc_b1(acc[1]), .b_b0(b_q[0]), .b_b1(b_q[1]), .f_b1(f_q[1]),
    .a_bit(a_sr[0]), .a_next(a_sr[1]), .d_bit(d_q), .d_next(d_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sr <= '0;
      b_q  <= '0;
      f_q  <= '0;
      acc  <= '0;
      d_q  <= 1'b0;
    end else if (load) begin
      a_sr <= a_in;
      b_q  <= b_in;
      f_q  <= {f_in[M-1:1], f_in[0] | 1'b1};  // constant term forced to 1
      acc  <= '0;
      d_q  <= a_in[0] & b_in[0];
    end else if (busy) begin
      a_sr <= a_sr >> 1;
      acc  <= acc_next;
      d_q  <= d_next;
    end
  end

  assign c_out = acc;

  assert_exact_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sum_lsb);
  assert_operands_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(b_q) && $stable(f_q)));
  assert_const_term_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> f_q[0]);
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  assert_hold_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(c_out));
endmodule

// File: tb/gf2m_mont_mul_test.sv
module gf2m_mont_mul_test;
  localparam int M = 8;
  localparam int CLK_PERIOD = 10;
  localparam logic [M-1:0] POLY_A = 8'h1B;
  localparam logic [M-1:0] POLY_B = 8'h1D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [M-1:0] a_in = '0, b_in = '0, f_in = '0;
  logic busy, done;
  logic [M-1:0] c_out;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gf2m_mont_mul #(.M(M)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .f_in(f_in), .busy(busy), .done(done), .c_out(c_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [M:0] full_poly(input logic [M-1:0] f);
    return {1'b1, f[M-1:1], 1'b1};
  endfunction

  // Ordinary modular product a*b mod f.
  function automatic logic [M-1:0] mulmod(input logic [M-1:0] a, input logic [M-1:0] b,
                                          input logic [M-1:0] f);
    logic [M:0] r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = r << 1;
      if (r[M]) r = r ^ full_poly(f);
      if (b[i]) r = r ^ {1'b0, a};
    end
    return r[M-1:0];
  endfunction

  // c * x^M mod f.
  function automatic logic [M-1:0] times_xm(input logic [M-1:0] c, input logic [M-1:0] f);
    logic [M:0] r = {1'b0, c};
    for (int i = 0; i < M; i++) begin
      r = r << 1;
      if (r[M]) r = r ^ full_poly(f);
    end
    return r[M-1:0];
  endfunction

  // One step of the plain recurrence: add a_i*b, reduce on low bit, divide by x.
  function automatic logic [M-1:0] ref_step(input logic [M-1:0] c, input logic ai,
                                            input logic [M-1:0] b, input logic [M-1:0] f);
    logic [M:0] t = {1'b0, c ^ (ai ? b : '0)};
    if (t[0]) t = t ^ full_poly(f);
    return t[M:1];
  endfunction

  // Cycle model
  logic         m_busy = 1'b0, m_done = 1'b0;
  logic [M-1:0] m_c = '0, m_a = '0, m_b = '0, m_f = '0;
  int           m_i = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_c = '0; m_i = 0;
    end else begin
      m_done = 1'b0;
      if (!m_busy && start) begin
        m_busy = 1'b1; m_c = '0; m_i = 0;
        m_a = a_in; m_b = b_in; m_f = f_in;
      end else if (m_busy) begin
        m_c = ref_step(m_c, m_a[m_i], m_b, m_f);
        m_i++;
        if (m_i == M) begin
          m_busy = 1'b0; m_done = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 busy", 32'(busy), 32'(m_busy));
      chk("R4 done", 32'(done), 32'(m_done));
      chk("R1/R9 accumulator", 32'(c_out), 32'(m_c));
    end
  end

  task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b, input logic [M-1:0] f,
                        input bit poke_start, input bit scramble, input string req);
    int n;
    logic [M-1:0] held;
    @(negedge clk);
    a_in = a; b_in = b; f_in = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 4 * M) begin
      if (n == 3 && poke_start) begin
        start = 1'b1; a_in = ~a; b_in = b ^ 8'h5A;
      end else begin
        start = 1'b0;
      end
      if (scramble) begin
        a_in = 8'($urandom); b_in = 8'($urandom); f_in = 8'($urandom);
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk("R3 latency", 32'(n), 32'(M + 1));
    chk({req, " identity"}, 32'(times_xm(c_out, f)), 32'(mulmod(a, b, f)));
    held = c_out;
    a_in = ~a_in; b_in = ~b_in;
    repeat (3) @(negedge clk);
    chk("R7 hold", 32'(c_out), 32'(held));
    chk("R4 pulse", 32'(done), 32'(0));
  endtask

  task automatic result_of(input logic [M-1:0] a, input logic [M-1:0] b,
                           input logic [M-1:0] f, output logic [M-1:0] r);
    run_op(a, b, f, 1'b0, 1'b0, "R2");
    r = c_out;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [M-1:0] r0, r1;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 busy", 32'(busy), 32'(0));
    chk("R8 done", 32'(done), 32'(0));
    chk("R8 c_out", 32'(c_out), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);

    run_op(8'h00, 8'hA7, POLY_A, 1'b0, 1'b0, "R1 a=0");
    chk("R1 a=0 result", 32'(c_out), 32'(0));
    run_op(8'h53, 8'h01, POLY_A, 1'b0, 1'b0, "R1 b=1");
    run_op(8'h80, 8'h80, POLY_A, 1'b0, 1'b0, "R1 x^7 squared");
    run_op(8'hFF, 8'hFF, POLY_B, 1'b0, 1'b0, "R1 all ones");
    run_op(8'h01, 8'h01, POLY_B, 1'b0, 1'b0, "R1 one");

    // R2: f_in[0] has no effect
    result_of(8'hC9, 8'h3E, POLY_A, r0);
    result_of(8'hC9, 8'h3E, POLY_A & 8'hFE, r1);
    chk("R2 f_in[0] ignored", 32'(r1), 32'(r0));
    result_of(8'h71, 8'hE4, POLY_B & 8'hFE, r1);
    chk("R2 constant term forced", 32'(times_xm(r1, POLY_B)), 32'(mulmod(8'h71, 8'hE4, POLY_B)));

    // R5: second start during a run
    run_op(8'h9D, 8'h6B, POLY_A, 1'b1, 1'b0, "R5 start ignored");
    // R6: operand inputs change during a run
    run_op(8'h2F, 8'hD3, POLY_B, 1'b0, 1'b1, "R6 operands captured");

    for (int k = 0; k < 40; k++) begin
      run_op(8'($urandom), 8'($urandom), (k % 2) ? POLY_B : POLY_A, 1'b0, 1'b0, "R1 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule